// File: doc/BRIEF.md
# Inline Ethernet Field Rewriter

The block sits on a byte-wide receive stream that has already had its preamble and start-of-frame delimiter removed. Each frame arrives as a contiguous run of valid bytes, with a start flag on the first destination-address byte and an end flag on the last byte of the frame check sequence. The block passes every byte through a fixed six-stage delay line. For frames it has been told to alter, it overwrites the destination address, the source address, the type/length field, or a window of up to six payload bytes. It then either keeps the original check sequence, writes a freshly computed CRC-32, or writes a user-chosen 32-bit value.

A load command arms the block for a number of frames, and every frame it alters uses up one of them. In conditional mode, only a frame whose original destination address equals a target address can be altered. The six-stage delay means the whole destination address has been seen before its first byte leaves the block. The same delay holds back the last four bytes of each frame, so they can be recognised as the check sequence when the end flag arrives.

Input frames must be at least 18 bytes long and must keep valid high from start to end. Configuration inputs other than the load command must stay stable while a frame is in flight. Six-byte values are applied with bits [47:40] as the first byte on the wire.

Top module: `frameFieldRewriter`

## Requirements
- R1: Every input byte and its start/end flags appear at the outputs exactly six clock cycles after they were presented, in the same order, whether or not the frame is altered.
- R2: While no frames are armed, every frame leaves the block bit-identical to how it entered, check sequence included.
- R3: In an altered frame with address replacement enabled, output bytes 0–5 carry `newDst` and bytes 6–11 carry `newSrc`, with bits [47:40] first.
- R4: With `matchOnly` set, a frame is altered only if its incoming bytes 0–5 equal `targetMac` (bits [47:40] against byte 0). A frame that does not match passes unchanged and does not use up an armed count.
- R5: With type replacement enabled, output byte 12 is `newType[15:8]` and byte 13 is `newType[7:0]`.
- R6: With payload editing enabled, payload byte `payOffset + j` (counted from frame byte 14), for j below `payLen` (at most 6), becomes `payData[47-8j -: 8]`.
- R7: A payload edit window that reaches the last four bytes of the frame is cut short there, and those four bytes are never changed as payload.
- R8: With `fcsMode` = 1, the last four bytes of an altered frame are the CRC-32 of all preceding output bytes, least significant byte first. The CRC uses polynomial 0x04C11DB7, reflected, with initial value all ones and final inversion. The whole output frame then leaves residue 0x2144DF1C.
- R9: With `fcsMode` = 2, the last four bytes of an altered frame are `userFcs`, least significant byte first. With `fcsMode` 0 or 3, the original check sequence is kept.
- R10: A pulse on `cmdLoad` arms `cmdFrames` frames. Each altered frame uses up one, and once the count reaches zero, later frames pass unchanged.
- R11: After reset the outputs are low and no frames are armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte valid |
| inStart | input | 1 | First byte of a frame (destination byte 0) |
| inEnd | input | 1 | Last byte of a frame (last check-sequence byte) |
| inData | input | 8 | Input byte |
| cmdLoad | input | 1 | Arm pulse |
| cmdFrames | input | 8 | Number of frames to alter |
| matchOnly | input | 1 | Alter only frames whose destination equals the target |
| targetMac | input | 48 | Destination address to match |
| dstEn | input | 1 | Replace destination address |
| newDst | input | 48 | Replacement destination |
| srcEn | input | 1 | Replace source address |
| newSrc | input | 48 | Replacement source |
| typeEn | input | 1 | Replace type/length |
| newType | input | 16 | Replacement type/length |
| payEn | input | 1 | Enable payload edit |
| payOffset | input | 11 | Edit start offset from payload byte 0 |
| payLen | input | 3 | Number of bytes to edit (0–6) |
| payData | input | 48 | Edit bytes, first at [47:40] |
| fcsMode | input | 2 | 0/3 keep, 1 recompute, 2 user value |
| userFcs | input | 32 | User check sequence |
| outValid | output | 1 | Output byte valid |
| outStart | output | 1 | First output byte of a frame |
| outEnd | output | 1 | Last output byte of a frame |
| outData | output | 8 | Output byte |

## Verification
Frames are sent with no frames armed, with address, type and payload edits, and with each check-sequence mode, so that the expected byte image can tell apart field position, byte order and check-sequence source. A payload window that runs into the check sequence shows whether the edit is cut short at the tail. A mismatching destination followed by a matching one shows whether the decision uses the original address and whether a mismatch leaves the count untouched. Three frames sent against a count of two show where arming stops, and the latency of every frame is measured from input start to output start.

// File: rtl/rwPkg.sv
package rwPkg;
  localparam int MAC_BYTES = 6;
  localparam int PAY_MAX   = 6;
  localparam int FCS_BYTES = 4;
  localparam int HDR_BYTES = 14;

  typedef enum logic [1:0] {
    FCS_KEEP = 2'd0,
    FCS_CALC = 2'd1,
    FCS_USER = 2'd2,
    FCS_HOLD = 2'd3
  } fcsModeT;

  typedef struct packed {
    logic       modify;
    logic       selDst;
    logic       selSrc;
    logic       selType;
    logic       selPay;
    logic       selFcs;
    logic [2:0] fieldIdx;
    logic [2:0] payIdx;
    logic [1:0] fcsIdx;
    logic [1:0] fcsMode;
    logic       crcRestart;
  } strobeT;

  // reflected CRC-32 update, one byte, LSB first
  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/rwControl.sv
module rwControl
  import rwPkg::*;
#(
  parameter int OFF_W = 11,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             headValid,
  input  logic             headStart,
  input  logic             headFcs,
  input  logic [47:0]      destWin,
  input  logic             cmdLoad,
  input  logic [CNT_W-1:0] cmdFrames,
  input  logic             matchOnly,
  input  logic [47:0]      targetMac,
  input  logic             dstEn,
  input  logic             srcEn,
  input  logic             typeEn,
  input  logic             payEn,
  input  logic [OFF_W-1:0] payOffset,
  input  logic [2:0]       payLen,
  input  logic [1:0]       fcsMode,
  output strobeT           stb
);
  localparam logic [OFF_W-1:0] SRC_AT  = OFF_W'(MAC_BYTES);
  localparam logic [OFF_W-1:0] TYPE_AT = OFF_W'(2 * MAC_BYTES);
  localparam logic [OFF_W-1:0] HDR_AT  = OFF_W'(HDR_BYTES);
  localparam logic [OFF_W-1:0] POS_MAX = '1;

  logic [CNT_W-1:0] remaining;
  logic             modActive;
  logic [OFF_W-1:0] posReg, posNow, rel;
  logic [OFF_W:0]   payEndAt;
  logic [1:0]       fcsCnt;
  logic             eligible, modNow, inPay;

  assign eligible = (remaining != '0) && (!matchOnly || (destWin == targetMac));
  assign modNow   = headStart ? eligible : modActive;
  assign posNow   = headStart ? '0 : posReg;
  assign rel      = posNow - HDR_AT;
  assign payEndAt = {1'b0, payOffset} + (OFF_W + 1)'(payLen);
  assign inPay    = payEn && (posNow >= HDR_AT) && (rel >= payOffset) &&
                    ({1'b0, rel} < payEndAt) && !headFcs;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remaining <= '0;
      modActive <= 1'b0;
      posReg    <= '0;
      fcsCnt    <= '0;
    end else begin
      if (cmdLoad)
        remaining <= cmdFrames;
      else if (headValid && headStart && eligible)
        remaining <= remaining - 1'b1;
      if (headValid && headStart)
        modActive <= eligible;
      if (headValid) begin
        posReg <= (posNow == POS_MAX) ? posNow : posNow + 1'b1;
        fcsCnt <= headFcs ? fcsCnt + 1'b1 : 2'd0;
      end
    end
  end

  always_comb begin
    stb            = '0;
    stb.modify     = headValid && modNow;
    stb.crcRestart = headStart;
    stb.fcsMode    = fcsMode;
    stb.fcsIdx     = fcsCnt;
    stb.selFcs     = headFcs;
    if (!headFcs) begin
      if (dstEn && posNow < SRC_AT) begin
        stb.selDst   = 1'b1;
        stb.fieldIdx = posNow[2:0];
      end else if (srcEn && posNow >= SRC_AT && posNow < TYPE_AT) begin
        stb.selSrc   = 1'b1;
        stb.fieldIdx = 3'(posNow - SRC_AT);
      end else if (typeEn && posNow >= TYPE_AT && posNow < HDR_AT) begin
        stb.selType  = 1'b1;
        stb.fieldIdx = 3'(posNow - TYPE_AT);
      end
    end
    stb.selPay = inPay;
    stb.payIdx = 3'(rel - payOffset);
  end

  // R10: without a load the count moves by at most one per cycle, downward
  p_count_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cmdLoad |=> (remaining == $past(remaining)) || (remaining == $past(remaining) - 1'b1));

  // R4: a mismatching frame in conditional mode leaves the count alone
  p_mismatch_keeps_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    (headValid && headStart && matchOnly && destWin != targetMac && !cmdLoad)
      |=> remaining == $past(remaining));
endmodule

// File: rtl/rwDatapath.sv
module rwDatapath
  import rwPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inStart,
  input  logic        inEnd,
  input  logic [7:0]  inData,
  input  strobeT      stb,
  input  logic [47:0] newDst,
  input  logic [47:0] newSrc,
  input  logic [15:0] newType,
  input  logic [47:0] payData,
  input  logic [31:0] userFcs,
  output logic        headValid,
  output logic        headStart,
  output logic        headFcs,
  output logic [47:0] destWin,
  output logic        outValid,
  output logic        outStart,
  output logic        outEnd,
  output logic [7:0]  outData
);
  localparam int DEPTH = MAC_BYTES;
  localparam int LAST  = DEPTH - 1;

  logic [7:0]       stData [DEPTH];
  logic [DEPTH-1:0] stValid, stStart, stEnd, stFcs;
  logic             endMark;
  logic [31:0]      crcReg, crcBase, crcFin;
  logic [2:0]       warmCnt;

  assign endMark = inValid && inEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stValid[0] <= 1'b0; stStart[0] <= 1'b0; stEnd[0] <= 1'b0; stFcs[0] <= 1'b0;
      stData[0]  <= '0;
    end else begin
      stValid[0] <= inValid;
      stStart[0] <= inValid && inStart;
      stEnd[0]   <= endMark;
      stFcs[0]   <= endMark;
      stData[0]  <= inData;
    end
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    logic fcsIn;
    if (g < FCS_BYTES) begin : g_tail
      assign fcsIn = stFcs[g-1] || endMark;
    end else begin : g_body
      assign fcsIn = stFcs[g-1];
    end
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stValid[g] <= 1'b0; stStart[g] <= 1'b0; stEnd[g] <= 1'b0; stFcs[g] <= 1'b0;
        stData[g]  <= '0;
      end else begin
        stValid[g] <= stValid[g-1];
        stStart[g] <= stStart[g-1];
        stEnd[g]   <= stEnd[g-1];
        stFcs[g]   <= fcsIn;
        stData[g]  <= stData[g-1];
      end
    end
    assign destWin[8*g +: 8] = stData[g];
  end
  assign destWin[7:0] = stData[0];

  assign headValid = stValid[LAST];
  assign headStart = stStart[LAST];
  assign headFcs   = stFcs[LAST];

  function automatic logic [7:0] pickByte(input logic [47:0] v, input logic [2:0] idx);
    logic [47:0] s;
    s = v << (8 * int'(idx));
    return s[47:40];
  endfunction

  assign crcFin = ~crcReg;

  always_comb begin
    outData = stData[LAST];
    if (stb.modify) begin
      if (stb.selFcs) begin
        case (stb.fcsMode)
          FCS_CALC: outData = crcFin[8*int'(stb.fcsIdx) +: 8];
          FCS_USER: outData = userFcs[8*int'(stb.fcsIdx) +: 8];
          default:  outData = stData[LAST];
        endcase
      end else if (stb.selDst)  outData = pickByte(newDst, stb.fieldIdx);
      else if (stb.selSrc)      outData = pickByte(newSrc, stb.fieldIdx);
      else if (stb.selType)     outData = stb.fieldIdx[0] ? newType[7:0] : newType[15:8];
      else if (stb.selPay)      outData = pickByte(payData, stb.payIdx);
    end
  end

  assign crcBase = stb.crcRestart ? 32'hFFFFFFFF : crcReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg  <= 32'hFFFFFFFF;
      warmCnt <= '0;
    end else begin
      if (headValid && !headFcs) crcReg <= crcByte(crcBase, outData);
      if (warmCnt != 3'(DEPTH)) warmCnt <= warmCnt + 1'b1;
    end
  end

  assign outValid = stValid[LAST];
  assign outStart = stStart[LAST];
  assign outEnd   = stEnd[LAST];

  // R1: output valid follows input valid six cycles later
  p_fixed_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == 3'(DEPTH)) |-> (outValid == $past(inValid, DEPTH)));

  p_start_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    outStart |-> outValid);

  // R2: bytes of an unaltered frame leave as they arrived
  p_unmodified_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !stb.modify) |-> outData == stData[LAST]);

  // R7: the frame end always falls inside the held tail
  p_end_in_fcs_r7: assert property (@(posedge clk) disable iff (!rstN)
    outEnd |-> headFcs);
endmodule

// File: rtl/frameFieldRewriter.sv
module frameFieldRewriter
  import rwPkg::*;
#(
  parameter int OFF_W = 11,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inStart,
  input  logic             inEnd,
  input  logic [7:0]       inData,
  input  logic             cmdLoad,
  input  logic [CNT_W-1:0] cmdFrames,
  input  logic             matchOnly,
  input  logic [47:0]      targetMac,
  input  logic             dstEn,
  input  logic [47:0]      newDst,
  input  logic             srcEn,
  input  logic [47:0]      newSrc,
  input  logic             typeEn,
  input  logic [15:0]      newType,
  input  logic             payEn,
  input  logic [OFF_W-1:0] payOffset,
  input  logic [2:0]       payLen,
  input  logic [47:0]      payData,
  input  logic [1:0]       fcsMode,
  input  logic [31:0]      userFcs,
  output logic             outValid,
  output logic             outStart,
  output logic             outEnd,
  output logic [7:0]       outData
);
  strobeT      stb;
  logic        headValid, headStart, headFcs;
  logic [47:0] destWin;

  rwControl #(.OFF_W(OFF_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .headValid(headValid), .headStart(headStart), .headFcs(headFcs), .destWin(destWin),
    .cmdLoad(cmdLoad), .cmdFrames(cmdFrames), .matchOnly(matchOnly), .targetMac(targetMac),
    .dstEn(dstEn), .srcEn(srcEn), .typeEn(typeEn), .payEn(payEn),
    .payOffset(payOffset), .payLen(payLen), .fcsMode(fcsMode), .stb(stb)
  );

  rwDatapath uData (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inStart(inStart), .inEnd(inEnd), .inData(inData),
    .stb(stb), .newDst(newDst), .newSrc(newSrc), .newType(newType),
    .payData(payData), .userFcs(userFcs),
    .headValid(headValid), .headStart(headStart), .headFcs(headFcs), .destWin(destWin),
    .outValid(outValid), .outStart(outStart), .outEnd(outEnd), .outData(outData)
  );
endmodule

// File: tb/frameFieldRewriter_test.sv
module frameFieldRewriter_test;
  localparam int CLK_PERIOD = 10;
  localparam int BUF = 256;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        inValid = 0, inStart = 0, inEnd = 0;
  logic [7:0]  inData = '0;
  logic        cmdLoad = 0;
  logic [7:0]  cmdFrames = '0;
  logic        matchOnly = 0, dstEn = 0, srcEn = 0, typeEn = 0, payEn = 0;
  logic [47:0] targetMac = '0, newDst = '0, newSrc = '0, payData = '0;
  logic [15:0] newType = '0;
  logic [10:0] payOffset = '0;
  logic [2:0]  payLen = '0;
  logic [1:0]  fcsMode = '0;
  logic [31:0] userFcs = '0;
  logic        outValid, outStart, outEnd;
  logic [7:0]  outData;

  frameFieldRewriter uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int inStartCyc, outStartCyc, outCnt, outEndIdx;
  logic [7:0] frm [BUF];
  logic [7:0] expB [BUF];
  logic [7:0] cap [BUF];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (outValid) begin
      if (outStart) begin outCnt = 0; outStartCyc = cyc; end
      if (outCnt < BUF) cap[outCnt] = outData;
      if (outEnd) outEndIdx = outCnt;
      outCnt = outCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] refCrc(input int n, input bit useExp);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {24'h0, useExp ? expB[i] : frm[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic logic [31:0] capCrc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {24'h0, cap[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic makeFrame(input int len, input logic [47:0] dst, input int seed);
    logic [31:0] f;
    for (int k = 0; k < 6; k++) frm[k] = dst[47-8*k -: 8];
    for (int k = 0; k < 6; k++) frm[6+k] = 8'h20 + 8'(k);
    frm[12] = 8'h08; frm[13] = 8'h00;
    for (int k = 14; k < len - 4; k++) frm[k] = 8'(k * 7 + seed);
    f = refCrc(len - 4, 0);
    for (int k = 0; k < 4; k++) frm[len-4+k] = f[8*k +: 8];
  endtask

  task automatic buildExp(input int len, input bit mod);
    logic [31:0] f;
    for (int k = 0; k < len; k++) expB[k] = frm[k];
    if (!mod) return;
    if (dstEn) for (int k = 0; k < 6; k++) expB[k] = newDst[47-8*k -: 8];
    if (srcEn) for (int k = 0; k < 6; k++) expB[6+k] = newSrc[47-8*k -: 8];
    if (typeEn) begin expB[12] = newType[15:8]; expB[13] = newType[7:0]; end
    if (payEn)
      for (int j = 0; j < int'(payLen); j++)
        if (14 + int'(payOffset) + j < len - 4) expB[14 + int'(payOffset) + j] = payData[47-8*j -: 8];
    if (fcsMode == 2'd1) begin
      f = refCrc(len - 4, 1);
      for (int k = 0; k < 4; k++) expB[len-4+k] = f[8*k +: 8];
    end else if (fcsMode == 2'd2)
      for (int k = 0; k < 4; k++) expB[len-4+k] = userFcs[8*k +: 8];
  endtask

  task automatic sendFrame(input int len);
    outCnt = 0; outEndIdx = -1; outStartCyc = -100;
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      if (i == 0) inStartCyc = cyc;
      inValid = 1; inStart = (i == 0); inEnd = (i == len - 1); inData = frm[i];
    end
    @(posedge clk); #1;
    inValid = 0; inStart = 0; inEnd = 0;
    repeat (10) @(posedge clk);
    #1;
  endtask

  task automatic runFrame(input int len, input bit mod, input string req);
    int bad = -1;
    buildExp(len, mod);
    sendFrame(len);
    check(outStartCyc - inStartCyc == 6, "R1", "latency", outStartCyc - inStartCyc, 6);
    check(outCnt == len && outEndIdx == len - 1, "R1", "length/end", outCnt, len);
    for (int k = len - 1; k >= 0; k--) if (cap[k] !== expB[k]) bad = k;
    if (bad < 0) check(1, req, "bytes", 0, 0);
    else check(0, req, $sformatf("byte %0d", bad), cap[bad], expB[bad]);
  endtask

  task automatic arm(input int n);
    @(posedge clk); #1; cmdLoad = 1; cmdFrames = 8'(n);
    @(posedge clk); #1; cmdLoad = 0;
  endtask

  task automatic clearCfg();
    matchOnly = 0; dstEn = 0; srcEn = 0; typeEn = 0; payEn = 0; fcsMode = 2'd0;
  endtask

  task automatic t_reset();
    check(!outValid && !outStart && !outEnd, "R11", "outputs after reset",
          {outValid, outStart, outEnd}, 0);
    makeFrame(40, 48'h0A1B2C3D4E5F, 1);
    runFrame(40, 0, "R11");
  endtask

  task automatic t_passthrough();
    clearCfg(); dstEn = 1; newDst = 48'hFFFFFFFFFFFF; fcsMode = 2'd1;
    makeFrame(64, 48'h001122334455, 9);
    runFrame(64, 0, "R2");
  endtask

  task automatic t_addr();
    clearCfg(); dstEn = 1; srcEn = 1; fcsMode = 2'd1;
    newDst = 48'hDE_AD_BE_EF_00_01; newSrc = 48'h12_34_56_78_9A_BC;
    arm(1);
    makeFrame(48, 48'h001122334455, 3);
    runFrame(48, 1, "R3");
    check(capCrc(48) == 32'h2144DF1C, "R8", "residue", capCrc(48), 32'h2144DF1C);
  endtask

  task automatic t_type_user();
    clearCfg(); typeEn = 1; newType = 16'h88F7; fcsMode = 2'd2; userFcs = 32'hC0FFEE42;
    arm(1);
    makeFrame(40, 48'h665544332211, 5);
    runFrame(40, 1, "R5");
    check(cap[36] == 8'h42 && cap[39] == 8'hC0, "R9", "user fcs order", {cap[36], cap[39]}, 16'h42C0);
  endtask

  task automatic t_payload();
    clearCfg(); payEn = 1; payOffset = 11'd3; payLen = 3'd4; fcsMode = 2'd1;
    payData = 48'hA1_A2_A3_A4_A5_A6;
    arm(1);
    makeFrame(50, 48'h0A0B0C0D0E0F, 11);
    runFrame(50, 1, "R6");
    check(cap[17] == 8'hA1 && cap[20] == 8'hA4 && cap[21] == frm[21], "R6", "window edges",
          {cap[17], cap[20]}, 16'hA1A4);
    check(capCrc(50) == 32'h2144DF1C, "R8", "residue after payload", capCrc(50), 32'h2144DF1C);
  endtask

  task automatic t_trunc();
    clearCfg(); payEn = 1; payOffset = 11'd10; payLen = 3'd6; fcsMode = 2'd0;
    payData = 48'hB1_B2_B3_B4_B5_B6;
    arm(1);
    makeFrame(30, 48'h0A0B0C0D0E0F, 2);
    runFrame(30, 1, "R7");
    check(cap[25] == 8'hB2 && cap[26] == frm[26] && cap[29] == frm[29], "R9", "kept fcs",
          {cap[26], cap[29]}, {frm[26], frm[29]});
  endtask

  task automatic t_match();
    clearCfg(); matchOnly = 1; targetMac = 48'h02_AA_BB_CC_DD_EE; dstEn = 1;
    newDst = 48'h02_00_00_00_00_99; fcsMode = 2'd1;
    arm(1);
    makeFrame(40, 48'h02_AA_BB_CC_DD_EF, 4);
    runFrame(40, 0, "R4");
    makeFrame(40, 48'h02_AA_BB_CC_DD_EE, 4);
    runFrame(40, 1, "R4");
    makeFrame(40, 48'h02_AA_BB_CC_DD_EE, 6);
    runFrame(40, 0, "R10");
  endtask

  task automatic t_count();
    clearCfg(); srcEn = 1; newSrc = 48'h77_66_55_44_33_22; fcsMode = 2'd1;
    arm(2);
    makeFrame(36, 48'h0011AA22BB33, 7);
    runFrame(36, 1, "R10");
    makeFrame(36, 48'h0011AA22BB33, 8);
    runFrame(36, 1, "R10");
    makeFrame(36, 48'h0011AA22BB33, 9);
    runFrame(36, 0, "R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    t_reset();
    t_passthrough();
    t_addr();
    t_type_user();
    t_payload();
    t_trunc();
    t_match();
    t_count();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule